// File: doc/BRIEF.md
# Bufferless Two-Uplink Tree Switch

This block is one switch in a single level of a butterfly fat-tree on-chip network. It has four links. Two go down to child subtrees, called left and right. Two go up to parent switches, called up-A and up-B. Every packet is a single flit: a destination leaf address, a payload and a one-bit deflected marker. There are no queues. Every packet that arrives in a cycle leaves on some output link in the next cycle.

A packet from a child climbs when its destination lies outside this switch's subtree. It may use either up link, and a two-state machine alternates the choice so that upward traffic is shared evenly. A packet from a parent, or a child packet whose destination lies below this switch, turns downward. It is steered by the destination bit selected by the level parameter. A packet that cannot have the link it wants is sent back on the link it came in on. It carries the deflected marker, and marked packets are served first at the next switch.

The level index `LVL` and the address prefix of this switch `SW_PREFIX` are parameters. Address bits above position `LVL` identify the subtree. Bit `LVL` picks left (0) or right (1).

Top module: `bft_dual_up_switch`

## Requirements
- R1: While reset is asserted and after reset, every output valid bit is 0. The up-link selector also resets to state UP_PICK_A, so the first lone climbing packet leaves on up-A.
- R2: A packet from a parent link with no competing request leaves on the child link given by destination bit `LVL` (0 = left, port 0; 1 = right, port 1). Its address and payload are unchanged and its deflected marker is 0. It appears exactly one clock after it is presented.
- R3: A child packet climbs when its address shifted right by `LVL+1` differs from `SW_PREFIX`. When both children climb in the same cycle, left takes the up link preferred by the selector and right takes the other.
- R4: The selector has two states. In UP_PICK_A it prefers up-A (port 2). In UP_PICK_B it prefers up-B (port 3). It moves to the other state after every cycle in which exactly one child packet climbs, and stays put otherwise.
- R5: A child packet whose destination lies below this switch turns down to the child link given by destination bit `LVL`.
- R6: Packets whose input deflected marker is 1 are allocated before unmarked packets. Within the same class the order is up-A, up-B, left, right.
- R7: A packet that loses its wanted link goes out on its own arrival link if that link is still free. Otherwise it takes the lowest-numbered free link (left = 0, right = 1, up-A = 2, up-B = 3). Its output deflected marker is 1, and a packet that gets a wanted link leaves with marker 0.
- R8: The number of valid outputs in a cycle equals the number of valid inputs in the cycle before. Each packet's address and payload appear on exactly one output.
- R9: Port k of every bus occupies bits `[k*W +: W]` of that bus, where W is the field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Valid per input link (0 left, 1 right, 2 up-A, 3 up-B) |
| in_defl | input | 4 | Deflected marker per input link |
| in_addr | input | 4*ADDR_W | Destination address per input link |
| in_data | input | 4*DATA_W | Payload per input link |
| out_vld | output | 4 | Valid per output link |
| out_defl | output | 4 | Deflected marker per output link |
| out_addr | output | 4*ADDR_W | Destination address per output link |
| out_data | output | 4*DATA_W | Payload per output link |

## Verification
The hardest case to reach is the fallback branch of R7. Here a loser's own arrival link has already been claimed by a packet of higher priority, so the loser lands on the lowest free link. That only happens when all four inputs are valid with a particular mix of climbing and turning destinations. A directed case builds that mix exactly: both parents aim at the two child links, and the left child also aims right. A long random run, with all four links usually busy and a quarter of the packets marked, then covers the priority and bounce orderings against a bench model of the allocation rules.

// File: rtl/bft_pkg.sv
package bft_pkg;
    localparam int NLINK = 4;

    typedef enum logic [1:0] {
        LINK_L  = 2'd0,
        LINK_R  = 2'd1,
        LINK_UA = 2'd2,
        LINK_UB = 2'd3
    } link_e;

    typedef enum logic {
        UP_PICK_A = 1'b0,
        UP_PICK_B = 1'b1
    } up_state_e;
endpackage

// File: rtl/bft_route_dec.sv
module bft_route_dec #(
    parameter int          ADDR_W    = 4,
    parameter int          LVL       = 1,
    parameter int unsigned SW_PREFIX = 1,
    parameter bit          IS_CHILD  = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              want_up,
    output logic              down_dir
);
    localparam int              SHIFT   = LVL + 1;
    localparam logic [ADDR_W-1:0] OWN_PFX = ADDR_W'(SW_PREFIX);

    logic [ADDR_W-1:0] dst_pfx;

    always_comb begin
        dst_pfx  = addr >> SHIFT;
        down_dir = addr[LVL];
        if (IS_CHILD) begin
            want_up = (dst_pfx != OWN_PFX);
        end else begin
            want_up = 1'b0;
        end
    end
endmodule

// File: rtl/bft_up_toggle.sv
module bft_up_toggle
    import bft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic single_up,
    output logic prefer_ub
);
    up_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= UP_PICK_A;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            UP_PICK_A: if (single_up) st_nx = UP_PICK_B;
            UP_PICK_B: if (single_up) st_nx = UP_PICK_A;
            default:   st_nx = UP_PICK_A;
        endcase
    end

    always_comb begin
        unique case (st)
            UP_PICK_A: prefer_ub = 1'b0;
            UP_PICK_B: prefer_ub = 1'b1;
            default:   prefer_ub = 1'b0;
        endcase
    end

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_up |=> (prefer_ub != $past(prefer_ub)));
endmodule

// File: rtl/bft_alloc.sv
module bft_alloc
    import bft_pkg::*;
(
    input  logic [NLINK-1:0]   vld,
    input  logic [NLINK-1:0]   defl,
    input  logic [NLINK-1:0]   want_up,
    input  logic [NLINK-1:0]   down_dir,
    input  logic               prefer_ub,
    output logic [2*NLINK-1:0] src_idx,
    output logic [NLINK-1:0]   used,
    output logic [NLINK-1:0]   prod
);
    always_comb begin
        logic [NLINK-1:0] busy;
        logic [1:0]       cur;
        logic [1:0]       pa;
        logic [1:0]       pb;
        logic [1:0]       take;
        logic             two_way;
        logic             ok;
        busy    = '0;
        src_idx = '0;
        prod    = '0;
        cur     = '0;
        pa      = '0;
        pb      = '0;
        take    = '0;
        two_way = 1'b0;
        ok      = 1'b0;
        // pass 0 serves marked packets, pass 1 the rest; order up-A, up-B, L, R
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < NLINK; k++) begin
                cur = 2'(k + 2);
                if (vld[cur] && (defl[cur] == (pass == 0))) begin
                    if (want_up[cur]) begin
                        pa      = prefer_ub ? LINK_UB : LINK_UA;
                        pb      = prefer_ub ? LINK_UA : LINK_UB;
                        two_way = 1'b1;
                    end else begin
                        pa      = down_dir[cur] ? LINK_R : LINK_L;
                        pb      = pa;
                        two_way = 1'b0;
                    end
                    ok = 1'b1;
                    if (!busy[pa]) begin
                        take = pa;
                    end else if (two_way && !busy[pb]) begin
                        take = pb;
                    end else begin
                        ok = 1'b0;
                        if (!busy[cur]) begin
                            take = cur;
                        end else begin
                            take = '0;
                            for (int j = NLINK - 1; j >= 0; j--) begin
                                if (!busy[j]) take = 2'(j);
                            end
                        end
                    end
                    busy[take]                   = 1'b1;
                    src_idx[int'(take)*2 +: 2]   = cur;
                    prod[take]                   = ok;
                end
            end
        end
        used = busy;
    end
endmodule

// File: rtl/bft_dual_up_switch.sv
module bft_dual_up_switch
    import bft_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 8,
    parameter int          LVL       = 1,
    parameter int unsigned SW_PREFIX = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLINK-1:0]        in_vld,
    input  logic [NLINK-1:0]        in_defl,
    input  logic [NLINK*ADDR_W-1:0] in_addr,
    input  logic [NLINK*DATA_W-1:0] in_data,
    output logic [NLINK-1:0]        out_vld,
    output logic [NLINK-1:0]        out_defl,
    output logic [NLINK*ADDR_W-1:0] out_addr,
    output logic [NLINK*DATA_W-1:0] out_data
);
    logic [ADDR_W-1:0]  a_in [NLINK];
    logic [DATA_W-1:0]  d_in [NLINK];
    logic [ADDR_W-1:0]  a_mux[NLINK];
    logic [DATA_W-1:0]  d_mux[NLINK];
    logic [NLINK-1:0]   up_req;
    logic [NLINK-1:0]   dn_dir;
    logic [2*NLINK-1:0] src_idx;
    logic [NLINK-1:0]   used;
    logic [NLINK-1:0]   prod;
    logic               prefer_ub;
    logic               single_up;

    for (genvar g = 0; g < NLINK; g++) begin : g_link
        assign a_in[g] = in_addr[g*ADDR_W +: ADDR_W];
        assign d_in[g] = in_data[g*DATA_W +: DATA_W];

        bft_route_dec #(
            .ADDR_W(ADDR_W), .LVL(LVL), .SW_PREFIX(SW_PREFIX),
            .IS_CHILD(g < 2)
        ) u_dec (
            .addr    (a_in[g]),
            .want_up (up_req[g]),
            .down_dir(dn_dir[g])
        );

        // four-way output select: other child, either parent, or own turn-back
        always_comb begin
            unique case (src_idx[g*2 +: 2])
                2'd0:    begin a_mux[g] = a_in[0]; d_mux[g] = d_in[0]; end
                2'd1:    begin a_mux[g] = a_in[1]; d_mux[g] = d_in[1]; end
                2'd2:    begin a_mux[g] = a_in[2]; d_mux[g] = d_in[2]; end
                default: begin a_mux[g] = a_in[3]; d_mux[g] = d_in[3]; end
            endcase
        end

        always_ff @(posedge clk) begin
            out_addr[g*ADDR_W +: ADDR_W] <= a_mux[g];
            out_data[g*DATA_W +: DATA_W] <= d_mux[g];
        end
    end

    assign single_up = (in_vld[0] && up_req[0]) ^ (in_vld[1] && up_req[1]);

    bft_up_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_up(single_up),
        .prefer_ub(prefer_ub)
    );

    bft_alloc u_alloc (
        .vld      (in_vld),
        .defl     (in_defl),
        .want_up  (up_req),
        .down_dir (dn_dir),
        .prefer_ub(prefer_ub),
        .src_idx  (src_idx),
        .used     (used),
        .prod     (prod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_defl <= '0;
        end else begin
            out_vld  <= used;
            out_defl <= used & ~prod;
        end
    end

    logic ua_dir;
    assign ua_dir = in_addr[2*ADDR_W + LVL];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (out_vld == '0));

    // R8
    count_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(out_vld) == $countones($past(in_vld))));

    // R6
    top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[2] && in_defl == '0) |=>
        (($past(ua_dir) ? out_vld[1] : out_vld[0]) && !$past(ua_dir) == !out_vld[1] | out_vld[0]));

    // R3
    both_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld == 4'b0011 && up_req[1:0] == 2'b11) |=>
        (out_vld == 4'b1100 && out_defl == '0));
endmodule

// File: tb/tb_bft_dual_up_switch.sv
module tb_bft_dual_up_switch;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int LV = 1;
    localparam int PFX = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    in_vld, in_defl;
    logic [4*AW-1:0] in_addr;
    logic [4*DW-1:0] in_data;
    logic [3:0]    out_vld, out_defl;
    logic [4*AW-1:0] out_addr;
    logic [4*DW-1:0] out_data;

    logic [3:0]    e_vld, e_defl;
    logic [4*AW-1:0] e_addr;
    logic [4*DW-1:0] e_data;
    logic          m_tog;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    bft_dual_up_switch #(.ADDR_W(AW), .DATA_W(DW), .LVL(LV), .SW_PREFIX(PFX)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_defl(in_defl), .in_addr(in_addr), .in_data(in_data),
        .out_vld(out_vld), .out_defl(out_defl), .out_addr(out_addr), .out_data(out_data)
    );

    // reference allocation computed from the written rules
    task automatic model_step();
        logic [3:0] taken;
        int         seq[4];
        int         ups;
        taken = '0; e_vld = '0; e_defl = '0; ups = 0;
        seq[0] = 2; seq[1] = 3; seq[2] = 0; seq[3] = 1;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 4; k++) begin
                int s;
                int dst;
                int p1;
                int p2;
                logic [AW-1:0] a;
                logic climb;
                logic good;
                s = seq[k];
                if (!in_vld[s] || (in_defl[s] != (pass == 0))) continue;
                a = in_addr[s*AW +: AW];
                climb = (s < 2) && (int'(a >> (LV + 1)) != PFX);
                if (climb) begin
                    p1 = m_tog ? 3 : 2; p2 = m_tog ? 2 : 3;
                end else begin
                    p1 = a[LV] ? 1 : 0; p2 = p1;
                end
                good = 1'b1;
                if (!taken[p1]) dst = p1;
                else if (!taken[p2]) dst = p2;
                else begin
                    good = 1'b0;
                    if (!taken[s]) dst = s;
                    else begin
                        dst = 0;
                        while (taken[dst]) dst++;
                    end
                end
                taken[dst] = 1'b1;
                e_vld[dst] = 1'b1;
                e_defl[dst] = !good;
                e_addr[dst*AW +: AW] = a;
                e_data[dst*DW +: DW] = in_data[s*DW +: DW];
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (in_vld[c] && (int'(in_addr[c*AW +: AW] >> (LV + 1)) != PFX)) ups++;
        end
        if (ups == 1) m_tog = !m_tog;
    endtask

    task automatic compare_model(string tag);
        logic bad;
        bad = (out_vld != e_vld);
        for (int p = 0; p < 4; p++) begin
            if (e_vld[p] && (out_defl[p] != e_defl[p] ||
                out_addr[p*AW +: AW] != e_addr[p*AW +: AW] ||
                out_data[p*DW +: DW] != e_data[p*DW +: DW])) bad = 1'b1;
        end
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: vld/defl/addr/data act %b %b %h %h exp %b %b %h %h", tag,
                     out_vld, out_defl, out_addr, out_data, e_vld, e_defl, e_addr, e_data);
        end
    endtask

    task automatic expect_port(int p, logic [DW-1:0] d, logic df, string tag);
        n_cmp++;
        if (!out_vld[p] || out_data[p*DW +: DW] != d || out_defl[p] != df) begin
            n_bad++;
            $display("FAIL %s: port %0d vld %b data %h defl %b exp data %h defl %b",
                     tag, p, out_vld[p], out_data[p*DW +: DW], out_defl[p], d, df);
        end
    endtask

    task automatic send(logic [3:0] v, logic [3:0] df, logic [4*AW-1:0] a,
                        logic [4*DW-1:0] d, string tag);
        in_vld = v; in_defl = df; in_addr = a; in_data = d;
        model_step();
        @(negedge clk);
        compare_model(tag);
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: act running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_vld = '0; in_defl = '0; in_addr = '0; in_data = '0;
        m_tog = 1'b0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (out_vld != 4'b0000) begin
            n_bad++;
            $display("FAIL R1: out_vld act %b exp 0000", out_vld);
        end
        rst_n = 1'b1;

        // R1 R4: lone climbers alternate starting at up-A
        send(4'b0001, 4'b0000, 16'h0000, 32'h000000A1, "R1 first climb");
        expect_port(2, 8'hA1, 1'b0, "R1 R4 up-A first");
        send(4'b0010, 4'b0000, 16'h0000, 32'h0000B200, "R4 second climb");
        expect_port(3, 8'hB2, 1'b0, "R4 up-B second");
        send(4'b0001, 4'b0000, 16'h0000, 32'h000000C3, "R4 third climb");
        expect_port(2, 8'hC3, 1'b0, "R4 back to up-A");
        send(4'b0000, 4'b0000, 16'h0000, 32'h0, "R4 idle");
        send(4'b0001, 4'b0000, 16'h0000, 32'h000000C4, "R4 fourth climb");
        expect_port(3, 8'hC4, 1'b0, "R4 idle holds state");

        // R2: descending packets steered by address bit LVL
        send(4'b0100, 4'b0000, 16'h0500, 32'h00AA0000, "R2 down left");
        expect_port(0, 8'hAA, 1'b0, "R2 left");
        send(4'b1000, 4'b0000, 16'h6000, 32'hBB000000, "R2 down right");
        expect_port(1, 8'hBB, 1'b0, "R2 right");

        // R3: both children climb (selector now UP_PICK_A)
        send(4'b0011, 4'b0000, 16'h00F0, 32'h00002211, "R3 both climb");
        expect_port(2, 8'h11, 1'b0, "R3 left on preferred");
        expect_port(3, 8'h22, 1'b0, "R3 right on other");

        // R5: children swap sides by turning
        send(4'b0011, 4'b0000, 16'h0046, 32'h00004433, "R5 turn");
        expect_port(1, 8'h33, 1'b0, "R5 left to right");
        expect_port(0, 8'h44, 1'b0, "R5 right to left");

        // R7: two parents fight for left, loser bounces on its own link
        send(4'b1100, 4'b0000, 16'h4400, 32'h66550000, "R7 bounce");
        expect_port(0, 8'h55, 1'b0, "R6 up-A wins");
        expect_port(3, 8'h66, 1'b1, "R7 loser returns");

        // R6: marked packet outranks unmarked
        send(4'b1100, 4'b1000, 16'h4400, 32'h88770000, "R6 marked first");
        expect_port(0, 8'h88, 1'b0, "R6 marked wins");
        expect_port(2, 8'h77, 1'b1, "R6 unmarked bounces");

        // R7 fallback: left child's own link already taken
        send(4'b1111, 4'b0000, 16'h4606, 32'h44332211, "R7 fallback");
        expect_port(2, 8'h11, 1'b1, "R7 lowest free link");

        // R8 R9: random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] v, df;
            logic [4*AW-1:0] a;
            logic [4*DW-1:0] d;
            v = 4'($urandom);
            if (($urandom % 4) != 0) v = v | 4'($urandom);
            df = '0;
            for (int p = 0; p < 4; p++) if (($urandom % 4) == 0) df[p] = 1'b1;
            a[0*AW +: AW] = AW'($urandom);
            a[1*AW +: AW] = AW'($urandom);
            a[2*AW +: AW] = {2'b01, 2'($urandom)};
            a[3*AW +: AW] = {2'b01, 2'($urandom)};
            d = $urandom;
            send(v, df, a, d, "R8 R9 random");
        end
        in_vld = '0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule